// File: doc/BRIEF.md
# Trigger Output Select and Hold

This block chooses which of five trigger events drives a single external trigger pin and then keeps the pin from changing too often. A three-bit select code picks one source: a software-set flag, either of two external trigger pins, the internal converter trigger, or the logic-analyzer trigger. Any other code blocks the output and drives it low. The chosen level reaches the pin through a single register, so a selected event appears one clock later with no filtering delay.

Every time the pin changes level, rising or falling, a hold counter is loaded from a run-time hold-period input. While the counter is non-zero the pin is frozen and changes of the selected source are ignored. When the counter expires, the pin takes whatever level the source has at that moment. That level change, if there is one, starts a fresh hold, so a transition that arrived during one hold cannot skip the hold of the next. A separate hold-off reset input clears the counter at once. A hold period of zero makes the pin follow the source every cycle.

Top module: `trig_out_hold`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released, the pin is low and the hold counter is empty.
- R2: Select codes map as follows: 1 = software flag, 2 = external input pin, 3 = external output-pin trigger, 4 = converter trigger, 5 = logic-analyzer trigger. Codes 0, 6 and 7 drive the pin low.
- R3: When no hold is active, the pin equals the selected source level sampled at the previous rising clock edge (one register of latency).
- R4: After the pin changes at an edge, it cannot change again until H+1 edges later, where H is the hold period in force at the change.
- R5: Source changes that occur while a hold is active are ignored. At the first edge after the hold ends, the pin takes the current source level. If that level equals the pin, no new hold starts.
- R6: The hold applies equally to rising and falling transitions.
- R7: A hold period of 0 makes the pin follow the selected source every cycle.
- R8: The hold-off reset clears the hold counter at the edge where it is sampled high. The pin does not change at that edge. At the next edge without hold-off reset, the pin follows the source.
- R9: The hold length is taken from the hold-period input at the edge where the pin changes. Later changes to that input do not alter a hold already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_rst | input | 1 | Synchronous clear of the hold counter |
| src_sel | input | 3 | Source select code |
| hold_period | input | 20 | Hold length in clock cycles |
| sw_flag | input | 1 | Software-set trigger flag |
| pin_in_trig | input | 1 | Trigger from the external input pin |
| pin_out_trig | input | 1 | Trigger from the external output-pin path |
| conv_trig | input | 1 | Internal converter trigger |
| la_trig | input | 1 | Logic-analyzer trigger |
| trig_pin | output | 1 | Registered trigger output pin |

## Verification
Without a hold, the pin is due one rising edge after its inputs are applied. Inputs are changed on the falling edge, and the pin is compared on the following falling edge against a reference that advances once per rising edge. After a change, the reference records the edge index at which the next change becomes allowed: the change edge plus H+1. A hold-off reset moves that index to the next edge. The bench compares on every cycle, so any early change or late follow is caught at the cycle where it occurs. The sweeps cover all eight select codes against all 32 source patterns, and several hold lengths under pseudo-random toggling.

// File: rtl/trig_hold_pkg.sv
package trig_hold_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF      = 3'd0,
    SEL_FLAG     = 3'd1,
    SEL_PIN_IN   = 3'd2,
    SEL_PIN_OUT  = 3'd3,
    SEL_CONV     = 3'd4,
    SEL_LA       = 3'd5
  } trig_sel_e;
endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
  import trig_hold_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] src_vec,
  output logic               sel_val
);
  logic [NUM_SRC-1:0] hit;

  // source g answers to code g+1; every other code leaves hit empty
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
    assign hit[g] = (sel == SEL_W'(g + 1)) & src_vec[g];
  end

  assign sel_val = |hit;
endmodule

// File: rtl/trig_hold_cnt.sv
module trig_hold_cnt #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_en   = clr | load | ~cnt_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)            cnt_d = '0;
    else if (load)      cnt_d = period;
    else if (!cnt_zero) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_zero);                                         // R8
  AST_LOAD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt_q == $past(period)));              // R9
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_zero && !clr && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
endmodule

// File: rtl/trig_out_hold.sv
module trig_out_hold
  import trig_hold_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_rst,
  input  logic [2:0]       src_sel,
  input  logic [CNT_W-1:0] hold_period,
  input  logic             sw_flag,
  input  logic             pin_in_trig,
  input  logic             pin_out_trig,
  input  logic             conv_trig,
  input  logic             la_trig,
  output logic             trig_pin
);
  logic               rst_n_i;
  logic [NUM_SRC-1:0] src_vec;
  logic               sel_val;
  logic               cnt_zero;
  logic               upd_ok;
  logic               lvl_change;
  logic               out_q;
  logic               out_d;

  trig_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // bit order follows select code minus one
  assign src_vec = {la_trig, conv_trig, pin_out_trig, pin_in_trig, sw_flag};

  trig_src_mux u_mux (
    .sel     (src_sel),
    .src_vec (src_vec),
    .sel_val (sel_val)
  );

  assign upd_ok     = cnt_zero & ~hold_rst;
  assign lvl_change = upd_ok & (sel_val != out_q);

  trig_hold_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (hold_rst),
    .load     (lvl_change),
    .period   (hold_period),
    .cnt_zero (cnt_zero)
  );

  always_comb begin
    out_d = out_q;
    if (lvl_change) out_d = sel_val;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)        out_q <= 1'b0;
    else if (lvl_change) out_q <= out_d;
  end

  assign trig_pin = out_q;

  AST_FOLLOW_SRC: assert property (@(posedge clk) disable iff (!rst_n_i)
    upd_ok |=> (trig_pin == $past(sel_val)));                  // R3
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cnt_zero || hold_rst) |=> $stable(trig_pin));            // R5
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_ok && (src_sel == SEL_OFF || src_sel > SEL_LA)) |=> !trig_pin); // R2
  AST_CHANGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!$stable(trig_pin) && $past(hold_period) != '0) |-> !cnt_zero); // R4
endmodule

// File: tb/test_trig_out_hold.sv
`timescale 1ns/1ps
module test_trig_out_hold;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hold_rst;
  logic [2:0]  src_sel;
  logic [19:0] hold_period;
  logic        sw_flag, pin_in_trig, pin_out_trig, conv_trig, la_trig;
  logic        trig_pin;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  int allow_at = 0;
  logic exp_pin = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  trig_out_hold i_trig_out_hold (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .src_sel(src_sel),
    .hold_period(hold_period), .sw_flag(sw_flag), .pin_in_trig(pin_in_trig),
    .pin_out_trig(pin_out_trig), .conv_trig(conv_trig), .la_trig(la_trig),
    .trig_pin(trig_pin)
  );

  function automatic logic src_level();
    case (src_sel)
      3'd1: return sw_flag;
      3'd2: return pin_in_trig;
      3'd3: return pin_out_trig;
      3'd4: return conv_trig;
      3'd5: return la_trig;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: trig_pin=%b expected %b", tag, edge_n, act, exp);
    end
  endtask

  // one rising edge of the reference, then compare on the falling edge
  task automatic cyc(input string tag);
    logic lvl;
    @(posedge clk);
    edge_n++;
    lvl = src_level();
    if (hold_rst) allow_at = edge_n + 1;
    else if (edge_n >= allow_at && lvl != exp_pin) begin
      exp_pin  = lvl;
      allow_at = edge_n + int'(hold_period) + 1;
    end
    @(negedge clk);
    check(tag, trig_pin, exp_pin);
  endtask

  task automatic set_src(input logic [4:0] v);
    {la_trig, conv_trig, pin_out_trig, pin_in_trig, sw_flag} = v;
  endtask

  function automatic logic rnd_bit();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[16];
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold_rst = 1'b0; src_sel = 3'd1; hold_period = '0;
    set_src(5'h1F);
    repeat (3) @(negedge clk);
    check("R1 in reset", trig_pin, 1'b0);
    set_src(5'h00);
    rst_n = 1'b1;
    repeat (3) cyc("R1 after release");

    // R2: every code against every source pattern, no hold
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 32; p++) begin
        src_sel = 3'(s);
        set_src(5'(p));
        cyc("R2 select map");
      end
    end

    // R3: single rising event seen exactly one edge later
    src_sel = 3'd4; set_src(5'h00); cyc("R3 idle");
    set_src(5'h08);
    cyc("R3 one-cycle latency");

    // R7: zero hold, toggle each cycle
    src_sel = 3'd1;
    for (int i = 0; i < 20; i++) begin
      sw_flag = ~sw_flag;
      cyc("R7 zero hold follow");
    end

    // R4/R6: rise then immediate fall with H=4
    sw_flag = 1'b0; cyc("R4 settle"); cyc("R4 settle");
    hold_period = 20'd4;
    sw_flag = 1'b1; cyc("R4 rise");
    sw_flag = 1'b0;
    for (int i = 0; i < 12; i++) cyc("R6 falling held");

    // R5: pseudo-random toggling across hold lengths
    src_sel = 3'd2;
    for (int h = 1; h <= 6; h++) begin
      hold_period = 20'(h);
      for (int i = 0; i < 80; i++) begin
        pin_in_trig = rnd_bit();
        cyc("R5 ignore during hold");
      end
    end

    // R5: source reverts during hold, no new hold at expiry
    hold_period = 20'd3; pin_in_trig = 1'b0;
    repeat (6) cyc("R5 settle");
    pin_in_trig = 1'b1; cyc("R5 rise");
    pin_in_trig = 1'b0; cyc("R5 pulse");
    pin_in_trig = 1'b1;
    repeat (6) cyc("R5 revert no rehold");

    // R8: hold-off reset mid-hold
    hold_period = 20'd10; pin_in_trig = 1'b0;
    repeat (14) cyc("R8 settle");
    pin_in_trig = 1'b1; cyc("R8 rise");
    pin_in_trig = 1'b0; cyc("R8 held");
    hold_rst = 1'b1; cyc("R8 no change at clear");
    hold_rst = 1'b0; cyc("R8 follows next edge");
    repeat (12) cyc("R8 new hold");

    // R9: shrink period during a running hold
    hold_period = 20'd8; pin_in_trig = 1'b1; cyc("R9 rise");
    pin_in_trig = 1'b0;
    hold_period = 20'd1;
    repeat (12) cyc("R9 hold unchanged");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule